// File: doc/BRIEF.md
# Per-Core System Timer Bank with Indexed Register Window

The block holds one free-running 64-bit counter for each CPU core. All counters start and stop together under one shared enable and tick at a rate set by a prescaler select. Software reaches the block's internal configuration through two bus-visible registers. It first writes the number of an internal register into the index register. It then reads or writes the data register, and that access lands on the internal register the index names.

There are two internal registers. The global control register holds the shared enable and a one-hot prescaler select. The global interrupt-mask register holds one bit per core. Each core's event input reaches its interrupt output only while that core's mask bit is set. Masking a core never stops its counter. With a 26 MHz input clock, the divide-by-2 select gives a 13 MHz count rate.

Top module: `core_timer_bank`

## Requirements
- R1: After reset every counter reads zero, and the control register, the mask register and the index register all read zero.
- R2: A bus write at byte address 0x4 loads the index register, and a read there returns the low IDX_W (default 8) bits of the last value written, with the upper bits zero. A bus write at byte address 0x0 loads the internal register the index selects, and a read there returns that register's value.
- R3: Control register (internal offset 0x0) bit 0 is a single enable that starts every per-core counter at once. All per-core counters hold identical values at all times.
- R4: Control bits 10:8 form a one-hot prescaler select: bit 8 gives one increment every clock, bit 9 one every 2 clocks, and bit 10 one every 4 clocks. Over 8 clocks this means 8, 4 or 2 increments.
- R5: When the prescaler select has no bit set, or more than one bit set, the counters hold their value even while enabled.
- R6: Clearing the enable freezes the counters at their current value without clearing them. Setting it again resumes counting from the held value.
- R7: The mask register (internal offset 0x30) has one bit per core, with bit i for core i. irq_o[i] equals core_evt_i[i] AND mask bit i. A cleared mask bit does not stop the counters.
- R8: Internal offsets other than 0x0 and 0x30 read as zero and ignore writes. Bus addresses other than 0x0 and 0x4 read as zero and ignore writes.
- R9: Control bits other than 0 and 10:8, and mask bits at or above NCORE, read as zero whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: 0x0 data register, 0x4 index register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read access |
| core_evt_i | input | NCORE | Raw per-core interrupt events |
| count_o | output | NCORE*CNT_W | Counter values, core i at bits [i*CNT_W +: CNT_W] |
| irq_o | output | NCORE | Masked per-core interrupt lines |

## Verification
The count rate is measured as the difference between two samples taken 8 clocks apart. Because 8 is a multiple of every divide ratio, the expected difference is 8, 4 or 2 whatever the prescaler phase, and this tells the three one-hot selects apart. The bench also writes an all-clear select and two multi-bit selects, which must each give a difference of zero. Enable-off and enable-on windows separate freezing from clearing. Two event patterns against one mask pattern separate masking from a stopped count. Writes to an unused internal offset, to an unused bus address and to reserved bits are each followed by reads of the registers they could have disturbed.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h30;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned DIV_LSB = 8;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned PSC_W   = 2;
  localparam logic [DIV_W-1:0] SEL_BY1 = 3'b001;
  localparam logic [DIV_W-1:0] SEL_BY2 = 3'b010;
  localparam logic [DIV_W-1:0] SEL_BY4 = 3'b100;
endpackage

// File: rtl/ctb_regwin.sv
module ctb_regwin
  import ctb_pkg::*;
#(
  parameter int unsigned NCORE  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [NCORE-1:0]  mask_o
);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(4);
  localparam logic [DATA_W-1:0] CTRL_WMASK =
    DATA_W'(((1 << DIV_W) - 1) << DIV_LSB) | DATA_W'(1 << EN_BIT);
  localparam logic [DATA_W-1:0] MASK_WMASK =
    {{(DATA_W-NCORE){1'b0}}, {NCORE{1'b1}}};

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic wr_idx, wr_dat, hit_ctrl, hit_mask, idx_ce, ctrl_ce, mask_ce;

  // next-state
  always_comb begin
    wr_idx   = bus_sel && bus_wr && (bus_addr == A_INDEX);
    wr_dat   = bus_sel && bus_wr && (bus_addr == A_DATA);
    hit_ctrl = (idx_q == IDX_W'(OFS_CTRL));
    hit_mask = (idx_q == IDX_W'(OFS_MASK));
    idx_ce   = wr_idx;
    ctrl_ce  = wr_dat && hit_ctrl;
    mask_ce  = wr_dat && hit_mask;
    idx_d    = bus_wdata[IDX_W-1:0];
    ctrl_d   = bus_wdata & CTRL_WMASK;
    mask_d   = bus_wdata & MASK_WMASK;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == A_INDEX) begin
        bus_rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
      end else if (bus_addr == A_DATA) begin
        if (hit_ctrl)      bus_rdata = ctrl_q;
        else if (hit_mask) bus_rdata = mask_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (idx_ce)  idx_q  <= idx_d;
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  assign en_o   = ctrl_q[EN_BIT];
  assign div_o  = ctrl_q[DIV_LSB +: DIV_W];
  assign mask_o = mask_q[NCORE-1:0];

  // R2: a data write through the control index lands in the outputs
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_DATA && idx_q == IDX_W'(OFS_CTRL))
    |=> (en_o == $past(bus_wdata[EN_BIT])) && (div_o == $past(bus_wdata[DIV_LSB +: DIV_W])));

  // R8: data writes at an unused index leave configuration untouched
  assert_unused_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_DATA &&
     idx_q != IDX_W'(OFS_CTRL) && idx_q != IDX_W'(OFS_MASK))
    |=> $stable(en_o) && $stable(div_o) && $stable(mask_o));

  // R7: mask write reaches the mask output
  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_DATA && idx_q == IDX_W'(OFS_MASK))
    |=> mask_o == $past(bus_wdata[NCORE-1:0]));
endmodule

// File: rtl/ctb_prescale.sv
module ctb_prescale
  import ctb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q, psc_d;
  logic run, sel_ok;

  always_comb begin
    sel_ok = (div_i == SEL_BY1) || (div_i == SEL_BY2) || (div_i == SEL_BY4);
    run    = en_i && sel_ok;
    psc_d  = run ? psc_q + PSC_W'(1) : '0;
    unique case (1'b1)
      (div_i == SEL_BY1): tick_o = run;
      (div_i == SEL_BY2): tick_o = run && psc_q[0];
      (div_i == SEL_BY4): tick_o = run && (psc_q == {PSC_W{1'b1}});
      default:            tick_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R4: divide-by-1 ticks on every enabled clock
  assert_by1_every_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && div_i == SEL_BY1) |-> tick_o);

  // R4: divide-by-2 never ticks in two consecutive cycles
  assert_by2_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i == SEL_BY2) |=> !(tick_o && div_i == SEL_BY2));
endmodule

// File: rtl/ctb_counter.sv
module ctb_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R4: each tick advances the count by exactly one
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> count_o == $past(count_o) + CNT_W'(1));

  // R6: no tick, no change
  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o));
endmodule

// File: rtl/core_timer_bank.sv
module core_timer_bank
  import ctb_pkg::*;
#(
  parameter int unsigned NCORE  = 4,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NCORE-1:0]       core_evt_i,
  output logic [NCORE*CNT_W-1:0] count_o,
  output logic [NCORE-1:0]       irq_o
);
  logic rst_meta_q, rst_sync_q;
  logic en;
  logic [DIV_W-1:0] div;
  logic [NCORE-1:0] mask;
  logic tick;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctb_regwin #(.NCORE(NCORE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regwin (
    .clk(clk), .rst_n(rst_sync_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_o(en), .div_o(div), .mask_o(mask)
  );

  ctb_prescale u_psc (
    .clk(clk), .rst_n(rst_sync_q), .en_i(en), .div_i(div), .tick_o(tick)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    ctb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_sync_q), .tick_i(tick),
      .count_o(count_o[g*CNT_W +: CNT_W])
    );
    assign irq_o[g] = core_evt_i[g] & mask[g];

    if (g > 0) begin : g_lock
      // R3: every core's counter matches core 0
      assert_lockstep_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
        count_o[g*CNT_W +: CNT_W] == count_o[CNT_W-1:0]);
    end
  end

  // R5: a select without exactly one bit set freezes the count
  assert_bad_sel_holds_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$onehot(div) |=> $stable(count_o));

  // R6: disabled bank keeps its value
  assert_disabled_holds_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !en |=> $stable(count_o));
endmodule

// File: tb/core_timer_bank_tb.sv
module core_timer_bank_tb;
  localparam int NCORE = 4;
  localparam int CNT_W = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr;
  logic [3:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NCORE-1:0] core_evt_i, irq_o;
  logic [NCORE*CNT_W-1:0] count_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  core_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_evt_i(core_evt_i), .count_o(count_o), .irq_o(irq_o)
  );

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] cnt(int k);
    return count_o[k*CNT_W +: CNT_W];
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic reg_write(logic [7:0] ofs, logic [31:0] d);
    bus_write(4'h4, {24'h0, ofs});
    bus_write(4'h0, d);
  endtask

  task automatic reg_read(logic [7:0] ofs, output logic [31:0] d);
    bus_write(4'h4, {24'h0, ofs});
    bus_read(4'h0, d);
  endtask

  // count advance over 8 clocks with no bus activity
  task automatic delta8(output logic [63:0] dlt);
    logic [63:0] c0;
    @(negedge clk);
    c0 = cnt(0);
    repeat (8) @(negedge clk);
    dlt = cnt(0) - c0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int k = 0; k < NCORE; k++) chk("R1", "counter after reset", cnt(k), 64'h0);
    bus_read(4'h4, d);   chk("R1", "index after reset", {32'h0, d}, 64'h0);
    reg_read(8'h00, d);  chk("R1", "control after reset", {32'h0, d}, 64'h0);
    reg_read(8'h30, d);  chk("R1", "mask after reset", {32'h0, d}, 64'h0);
    chk("R1", "counter still zero while disabled", cnt(0), 64'h0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    bus_write(4'h4, 32'h0000_0030);
    bus_read(4'h4, d);   chk("R2", "index readback", {32'h0, d}, 64'h30);
    bus_write(4'h0, 32'h0000_0006);
    bus_read(4'h0, d);   chk("R2", "data readback via index", {32'h0, d}, 64'h6);
    bus_write(4'h4, 32'h1234_5600);
    bus_read(4'h4, d);   chk("R2", "index keeps low 8 bits", {32'h0, d}, 64'h0);
    reg_write(8'h30, 32'h0);
  endtask

  task automatic t_rates();
    logic [63:0] dl;
    reg_write(8'h00, 32'h0000_0101);
    delta8(dl); chk("R4", "divide-by-1 increments per 8 clocks", dl, 64'd8);
    for (int k = 1; k < NCORE; k++) chk("R3", "cores in lockstep", cnt(k), cnt(0));
    reg_write(8'h00, 32'h0000_0201);
    delta8(dl); chk("R4", "divide-by-2 increments per 8 clocks", dl, 64'd4);
    reg_write(8'h00, 32'h0000_0401);
    delta8(dl); chk("R4", "divide-by-4 increments per 8 clocks", dl, 64'd2);
    for (int k = 1; k < NCORE; k++) chk("R3", "cores in lockstep at div4", cnt(k), cnt(0));
  endtask

  task automatic t_badsel();
    logic [63:0] dl;
    reg_write(8'h00, 32'h0000_0001);
    delta8(dl); chk("R5", "empty select holds", dl, 64'd0);
    reg_write(8'h00, 32'h0000_0301);
    delta8(dl); chk("R5", "two-bit select holds", dl, 64'd0);
    reg_write(8'h00, 32'h0000_0701);
    delta8(dl); chk("R5", "three-bit select holds", dl, 64'd0);
  endtask

  task automatic t_disable();
    logic [63:0] dl, held;
    reg_write(8'h00, 32'h0000_0101);
    repeat (5) @(negedge clk);
    reg_write(8'h00, 32'h0000_0100);
    held = cnt(0);
    chk("R6", "held value not cleared", {63'h0, held == 64'h0}, 64'h0);
    delta8(dl); chk("R6", "disabled holds", dl, 64'd0);
    chk("R6", "value kept while disabled", cnt(0), held);
    reg_write(8'h00, 32'h0000_0101);
    delta8(dl); chk("R6", "resume after re-enable", dl, 64'd8);
    chk("R6", "resumed from held value", {63'h0, cnt(0) > held}, 64'h1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    logic [63:0] dl;
    reg_write(8'h30, 32'h0000_0005);
    reg_read(8'h30, d); chk("R7", "mask readback", {32'h0, d}, 64'h5);
    core_evt_i = 4'hF; #1;
    chk("R7", "irq with all events", {60'h0, irq_o}, 64'h5);
    core_evt_i = 4'hA; #1;
    chk("R7", "irq masked events", {60'h0, irq_o}, 64'h0);
    core_evt_i = 4'h3; #1;
    chk("R7", "irq partial", {60'h0, irq_o}, 64'h1);
    delta8(dl); chk("R7", "masking keeps counting", dl, 64'd8);
    core_evt_i = '0;
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    reg_write(8'h10, 32'hFFFF_FFFF);
    bus_read(4'h0, d); chk("R8", "unused offset reads zero", {32'h0, d}, 64'h0);
    reg_read(8'h00, d); chk("R8", "control unchanged", {32'h0, d}, 64'h101);
    reg_read(8'h30, d); chk("R8", "mask unchanged", {32'h0, d}, 64'h5);
    bus_write(4'h8, 32'h0000_0000);
    bus_read(4'h4, d); chk("R8", "index unchanged by bad address", {32'h0, d}, 64'h30);
    bus_read(4'h0, d); chk("R8", "mask unchanged by bad address", {32'h0, d}, 64'h5);
    bus_read(4'h8, d); chk("R8", "bad address reads zero", {32'h0, d}, 64'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    reg_write(8'h00, 32'hFFFF_FFFF);
    bus_read(4'h0, d); chk("R9", "control reserved bits", {32'h0, d}, 64'h701);
    reg_write(8'h30, 32'hFFFF_FFFF);
    bus_read(4'h0, d); chk("R9", "mask upper bits", {32'h0, d}, 64'hF);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; core_evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_window();
    t_rates();
    t_badsel();
    t_disable();
    t_mask();
    t_unimpl();
    t_reserved();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule